// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Cache

This block is a small data cache with two ways in every set. It sits between a processor port and a backing memory that moves whole blocks. The processor port is word-addressed and handles one request at a time. The block accepts a request while `req_ready` is high. It answers with a single-cycle `rsp_valid` pulse that carries the read word, or the written word for a store. Requests that hit are answered without any memory traffic. Requests that miss wait while a victim is chosen, written back if it holds modified data, and refilled from memory.

The word address is split into three fields. The tag is in the upper bits, the set index is in the middle, and the word offset is in the lower bits. The two ways of the selected set are compared against the tag in parallel, and a multiplexer picks the word from the matching way. A miss fills an invalid way if the set has one. Otherwise it replaces the way that was touched least recently, tracked with one bit per set. Writes change only the cache and mark the block modified. Memory sees the new data only when that block is evicted.

Top module: `assoc2_cache`

## Requirements
- R1: With the default parameters, address bits [1:0] select the word within a block, bits [4:2] select one of eight sets, and bits [11:5] form the tag. `mem_addr` carries the block address, which is the request address without its two offset bits.
- R2: A read that hits returns the stored word with `rsp_valid` high in the second cycle after acceptance, and `mem_req` stays low.
- R3: At most one way of the selected set matches the request tag.
- R4: A write that hits updates only the cached word and marks the block modified. It causes no memory traffic, and a later read returns the new value.
- R5: On a miss, an invalid way of the set is filled before any valid way is replaced, so two tags of one set can be resident together.
- R6: When both ways are valid, a miss replaces the way that was least recently hit or filled.
- R7: On a miss the whole block is read from memory with `mem_we` low and installed. The request is then served from the new block.
- R8: A modified victim is written to memory as a full block at its own block address before the refill read is issued. A clean victim causes no memory write.
- R9: `req_ready` is high only while idle. It stays low from the cycle after acceptance through the response cycle, and `rsp_valid` lasts exactly one cycle.
- R10: Reset clears every valid and modified bit, so after reset every access misses and no earlier store is ever written back.
- R11: Once `mem_req` is raised, it stays high with a stable `mem_addr` and `mem_we` until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | WORD_W | Store data |
| req_ready | output | 1 | Request accepted this cycle when high |
| rsp_valid | output | 1 | Response pulse |
| rsp_rdata | output | WORD_W | Loaded word, or the stored word for a store |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = block write-back, 0 = block read |
| mem_addr | output | ADDR_W-log2(BLK_WORDS) | Block address |
| mem_wdata | output | WORD_W*BLK_WORDS | Block being written back |
| mem_ack | input | 1 | Transfer complete, read block valid |
| mem_rdata | input | WORD_W*BLK_WORDS | Block returned by a read |

## Verification
The interesting overlap is a store that misses in a set whose least recently used way is modified. The eviction of the old block and the installation of the store data both happen inside one transaction. The test first dirties one way, fills the other way of the same set, and then issues a store to a third tag. It judges the result in three ways: the memory model must see a full-block write carrying the earlier store before it sees the refill read; the new store must read back as a hit; and re-reading the evicted address must return the earlier store from memory.

// File: rtl/assoc2_cache_pkg.sv
package assoc2_cache_pkg;

   localparam int unsigned NUM_WAYS = 2;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_COMPARE,
      ST_WRITEBACK,
      ST_REFILL,
      ST_RESPOND
   } cache_state_e;

endpackage

// File: rtl/cache_way_store.sv
module cache_way_store #(
   parameter int unsigned SETS      = 8,
   parameter int unsigned TAG_W     = 7,
   parameter int unsigned WORD_W    = 32,
   parameter int unsigned BLK_WORDS = 4
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic [$clog2(SETS)-1:0]            set_idx,
   output logic [TAG_W-1:0]                   tag_o,
   output logic                               valid_o,
   output logic                               dirty_o,
   output logic [WORD_W*BLK_WORDS-1:0]        block_o,
   input  logic                               fill_en,
   input  logic [TAG_W-1:0]                   fill_tag,
   input  logic [WORD_W*BLK_WORDS-1:0]        fill_block,
   input  logic                               wr_en,
   input  logic [$clog2(BLK_WORDS)-1:0]       wr_off,
   input  logic [WORD_W-1:0]                  wr_word
);
   localparam int unsigned BLK_W = WORD_W * BLK_WORDS;
   localparam int unsigned OFF_W = $clog2(BLK_WORDS);

   logic [BLK_W-1:0] data_q  [SETS];
   logic [TAG_W-1:0] tag_q   [SETS];
   logic [SETS-1:0]  valid_q;
   logic [SETS-1:0]  dirty_q;

   // state bits: reset clears them all
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
         dirty_q <= '0;
      end else if (fill_en) begin
         valid_q[set_idx] <= 1'b1;
         dirty_q[set_idx] <= 1'b0;
      end else if (wr_en) begin
         dirty_q[set_idx] <= 1'b1;
      end
   end

   // tag and data arrays carry no reset
   always_ff @(posedge clk) begin
      if (fill_en) begin
         tag_q[set_idx]  <= fill_tag;
         data_q[set_idx] <= fill_block;
      end else if (wr_en) begin
         for (int k = 0; k < int'(BLK_WORDS); k++) begin
            if (wr_off == OFF_W'(k))
               data_q[set_idx][k*WORD_W +: WORD_W] <= wr_word;
         end
      end
   end

   assign tag_o   = tag_q[set_idx];
   assign valid_o = valid_q[set_idx];
   assign dirty_o = dirty_q[set_idx];
   assign block_o = data_q[set_idx];

   a_r4_dirty_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
      dirty_o |-> valid_o)
      else $error("modified bit set on an invalid line");

   a_r10_fill_is_clean: assert property (@(posedge clk) disable iff (!rst_n)
      fill_en |=> (valid_o && !dirty_o) || !$stable(set_idx))
      else $error("freshly filled line not clean and valid");

endmodule

// File: rtl/cache_victim_pick.sv
module cache_victim_pick (
   input  logic [1:0] way_valid,
   input  logic       lru_way,
   output logic       victim_way
);
   always_comb begin
      if (!way_valid[0])      victim_way = 1'b0;
      else if (!way_valid[1]) victim_way = 1'b1;
      else                    victim_way = lru_way;
   end
endmodule

// File: rtl/cache_lru_bits.sv
module cache_lru_bits #(
   parameter int unsigned SETS = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [$clog2(SETS)-1:0] set_idx,
   input  logic                    touch_en,
   input  logic                    touch_way,
   output logic                    lru_way
);
   logic [SETS-1:0] lru_q;

   // each bit names the way not touched most recently
   always_ff @(posedge clk) begin
      if (!rst_n)        lru_q <= '0;
      else if (touch_en) lru_q[set_idx] <= ~touch_way;
   end

   assign lru_way = lru_q[set_idx];

   a_r6_lru_points_away: assert property (@(posedge clk) disable iff (!rst_n)
      touch_en |=> (lru_way != $past(touch_way)) || !$stable(set_idx))
      else $error("replacement bit points at the way just used");

endmodule

// File: rtl/assoc2_cache.sv
module assoc2_cache
   import assoc2_cache_pkg::*;
#(
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned WORD_W    = 32,
   parameter int unsigned BLK_WORDS = 4,
   parameter int unsigned SETS      = 8
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   req_valid,
   input  logic                                   req_write,
   input  logic [ADDR_W-1:0]                      req_addr,
   input  logic [WORD_W-1:0]                      req_wdata,
   output logic                                   req_ready,
   output logic                                   rsp_valid,
   output logic [WORD_W-1:0]                      rsp_rdata,
   output logic                                   mem_req,
   output logic                                   mem_we,
   output logic [ADDR_W-$clog2(BLK_WORDS)-1:0]    mem_addr,
   output logic [WORD_W*BLK_WORDS-1:0]            mem_wdata,
   input  logic                                   mem_ack,
   input  logic [WORD_W*BLK_WORDS-1:0]            mem_rdata
);
   localparam int unsigned OFF_W   = $clog2(BLK_WORDS);
   localparam int unsigned IDX_W   = $clog2(SETS);
   localparam int unsigned TAG_W   = ADDR_W - IDX_W - OFF_W;
   localparam int unsigned BLK_W   = WORD_W * BLK_WORDS;

   // elaboration-time parameter checks
   if (BLK_WORDS < 2 || (BLK_WORDS & (BLK_WORDS - 1)) != 0) begin : g_bad_blk
      $error("BLK_WORDS must be a power of two of at least 2");
   end
   if (SETS < 2 || (SETS & (SETS - 1)) != 0) begin : g_bad_sets
      $error("SETS must be a power of two of at least 2");
   end
   if (ADDR_W <= IDX_W + OFF_W) begin : g_bad_addr
      $error("ADDR_W leaves no tag bits");
   end

   cache_state_e      state_q, state_d;
   logic [ADDR_W-1:0] addr_q;
   logic              write_q;
   logic [WORD_W-1:0] wdata_q;
   logic              victim_q;
   logic [WORD_W-1:0] rdata_q;

   logic [OFF_W-1:0]  off_q;
   logic [IDX_W-1:0]  idx_q;
   logic [TAG_W-1:0]  tag_q;

   assign off_q = addr_q[OFF_W-1:0];
   assign idx_q = addr_q[OFF_W +: IDX_W];
   assign tag_q = addr_q[ADDR_W-1 -: TAG_W];

   logic [TAG_W-1:0]    way_tag   [NUM_WAYS];
   logic [BLK_W-1:0]    way_block [NUM_WAYS];
   logic [NUM_WAYS-1:0] way_valid;
   logic [NUM_WAYS-1:0] way_dirty;
   logic [NUM_WAYS-1:0] hit_vec;
   logic [NUM_WAYS-1:0] fill_vec;
   logic [NUM_WAYS-1:0] wr_vec;

   logic hit_any, hit_way, victim_c, lru_way;
   logic touch_en, touch_way;
   logic in_compare, refill_done;

   assign in_compare  = (state_q == ST_COMPARE);
   assign refill_done = (state_q == ST_REFILL) && mem_ack;
   assign hit_any     = |hit_vec;
   assign hit_way     = hit_vec[1];

   for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
      cache_way_store #(
         .SETS(SETS), .TAG_W(TAG_W), .WORD_W(WORD_W), .BLK_WORDS(BLK_WORDS)
      ) i_store (
         .clk       (clk),
         .rst_n     (rst_n),
         .set_idx   (idx_q),
         .tag_o     (way_tag[w]),
         .valid_o   (way_valid[w]),
         .dirty_o   (way_dirty[w]),
         .block_o   (way_block[w]),
         .fill_en   (fill_vec[w]),
         .fill_tag  (tag_q),
         .fill_block(mem_rdata),
         .wr_en     (wr_vec[w]),
         .wr_off    (off_q),
         .wr_word   (wdata_q)
      );
      // both tags compared side by side
      assign hit_vec[w]  = way_valid[w] && (way_tag[w] == tag_q);
      assign fill_vec[w] = refill_done && (victim_q == 1'(w));
      assign wr_vec[w]   = in_compare && write_q && hit_vec[w];
   end

   // way-select multiplexer, then word select
   logic [BLK_W-1:0]  hit_block;
   logic [WORD_W-1:0] hit_words [BLK_WORDS];
   assign hit_block = way_block[hit_way];
   for (genvar k = 0; k < BLK_WORDS; k++) begin : g_word
      assign hit_words[k] = hit_block[k*WORD_W +: WORD_W];
   end

   cache_victim_pick i_victim (
      .way_valid (way_valid),
      .lru_way   (lru_way),
      .victim_way(victim_c)
   );

   assign touch_en  = (in_compare && hit_any) || refill_done;
   assign touch_way = refill_done ? victim_q : hit_way;

   cache_lru_bits #(.SETS(SETS)) i_lru (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_idx  (idx_q),
      .touch_en (touch_en),
      .touch_way(touch_way),
      .lru_way  (lru_way)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:      if (req_valid) state_d = ST_COMPARE;
         ST_COMPARE: begin
            if (hit_any)                                        state_d = ST_RESPOND;
            else if (way_valid[victim_c] && way_dirty[victim_c]) state_d = ST_WRITEBACK;
            else                                                state_d = ST_REFILL;
         end
         ST_WRITEBACK: if (mem_ack) state_d = ST_REFILL;
         ST_REFILL:    if (mem_ack) state_d = ST_COMPARE;
         ST_RESPOND:   state_d = ST_IDLE;
         default:      state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         addr_q   <= '0;
         write_q  <= 1'b0;
         wdata_q  <= '0;
         victim_q <= 1'b0;
         rdata_q  <= '0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_IDLE && req_valid) begin
            addr_q  <= req_addr;
            write_q <= req_write;
            wdata_q <= req_wdata;
         end
         if (in_compare && !hit_any) victim_q <= victim_c;
         if (in_compare && hit_any)  rdata_q  <= write_q ? wdata_q : hit_words[off_q];
      end
   end

   assign req_ready = (state_q == ST_IDLE);
   assign rsp_valid = (state_q == ST_RESPOND);
   assign rsp_rdata = rdata_q;
   assign mem_req   = (state_q == ST_WRITEBACK) || (state_q == ST_REFILL);
   assign mem_we    = (state_q == ST_WRITEBACK);
   assign mem_addr  = (state_q == ST_WRITEBACK) ? {way_tag[victim_q], idx_q} : {tag_q, idx_q};
   assign mem_wdata = way_block[victim_q];

   a_r3_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
      in_compare |-> $onehot0(hit_vec))
      else $error("both ways match one tag");

   a_r2_hit_no_traffic: assert property (@(posedge clk) disable iff (!rst_n)
      (in_compare && hit_any) |=> !mem_req && rsp_valid)
      else $error("hit produced memory traffic or no response");

   a_r9_busy_at_response: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !req_ready)
      else $error("ready raised during response");

   a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid)
      else $error("response longer than one cycle");

   a_r11_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> mem_req && $stable(mem_addr) && $stable(mem_we))
      else $error("memory request changed before acknowledge");

   a_r8_read_after_writeback: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && mem_ack) |=> mem_req && !mem_we)
      else $error("write-back not followed by refill read");

endmodule

// File: tb/test_assoc2_cache.sv
module test_assoc2_cache;
   localparam int ADDR_W = 12;
   localparam int WORD_W = 32;
   localparam int BLK_WORDS = 4;
   localparam int SETS = 8;
   localparam int BLK_W = WORD_W * BLK_WORDS;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic req_write = 1'b0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic [WORD_W-1:0] req_wdata = '0;
   logic req_ready, rsp_valid;
   logic [WORD_W-1:0] rsp_rdata;
   logic mem_req, mem_we;
   logic [ADDR_W-3:0] mem_addr;
   logic [BLK_W-1:0] mem_wdata;
   logic mem_ack = 1'b0;
   logic [BLK_W-1:0] mem_rdata = '0;

   always #10 clk = ~clk;

   assoc2_cache #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .BLK_WORDS(BLK_WORDS), .SETS(SETS))
   i_assoc2_cache (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata));

   int n_checks = 0;
   int n_fail = 0;
   bit done = 0;

   logic [31:0] mem_words [1 << ADDR_W];
   int rd_count = 0, wb_count = 0, op_seq = 0, rd_seq = 0, wb_seq = 0;
   logic [ADDR_W-3:0] last_rd_addr = '0, last_wb_addr = '0;

   function automatic logic [31:0] init_word(input int a);
      return 32'hA500_0000 | a;
   endfunction

   function automatic logic [ADDR_W-1:0] mk(input int tag, input int idx, input int off);
      return {tag[6:0], idx[2:0], off[1:0]};
   endfunction

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // backing memory model: two-cycle latency, whole-block transfers
   initial begin
      forever begin
         @(negedge clk);
         if (mem_req && !mem_ack) begin
            repeat (2) @(negedge clk);
            op_seq++;
            if (mem_we) begin
               for (int k = 0; k < BLK_WORDS; k++)
                  mem_words[int'(mem_addr) * BLK_WORDS + k] = mem_wdata[k*WORD_W +: WORD_W];
               wb_count++; last_wb_addr = mem_addr; wb_seq = op_seq;
            end else begin
               for (int k = 0; k < BLK_WORDS; k++)
                  mem_rdata[k*WORD_W +: WORD_W] = mem_words[int'(mem_addr) * BLK_WORDS + k];
               rd_count++; last_rd_addr = mem_addr; rd_seq = op_seq;
            end
            mem_ack = 1'b1;
            @(negedge clk);
            mem_ack = 1'b0;
         end
      end
   end

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic access(input bit wr, input logic [ADDR_W-1:0] a, input logic [31:0] wd,
                         output logic [31:0] rd, output int lat);
      bit busy_bad = 0;
      @(negedge clk);
      check(req_ready === 1'b1, "R9 ready while idle", {31'd0, req_ready}, 32'd1);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
      @(negedge clk);
      req_valid = 1'b0;
      lat = 1;
      while (!rsp_valid && lat < 80) begin
         if (req_ready) busy_bad = 1;
         @(negedge clk);
         lat++;
      end
      if (req_ready) busy_bad = 1;
      check(!busy_bad, "R9 busy until response", {31'd0, busy_bad}, 32'd0);
      check(rsp_valid === 1'b1, "R9 response arrives", {31'd0, rsp_valid}, 32'd1);
      rd = rsp_rdata;
   endtask

   task automatic t_reset_state();
      check(req_ready === 1'b1, "R9 reset ready", {31'd0, req_ready}, 32'd1);
      check(rsp_valid === 1'b0, "R9 reset no response", {31'd0, rsp_valid}, 32'd0);
      check(mem_req === 1'b0, "R10 reset no memory request", {31'd0, mem_req}, 32'd0);
   endtask

   task automatic t_miss_then_hit();
      logic [31:0] d; int lat; int r0;
      r0 = rd_count;
      access(0, mk(1, 2, 3), 0, d, lat);
      check(rd_count == r0 + 1, "R7 miss reads one block", rd_count, r0 + 1);
      check(last_rd_addr == mk(1, 2, 3) >> 2, "R1 block address of refill", last_rd_addr, mk(1, 2, 3) >> 2);
      check(d == init_word(mk(1, 2, 3)), "R7 word served after fill", d, init_word(mk(1, 2, 3)));
      access(0, mk(1, 2, 0), 0, d, lat);
      check(lat == 2, "R2 hit latency", lat, 2);
      check(rd_count == r0 + 1, "R2 hit without memory", rd_count, r0 + 1);
      check(d == init_word(mk(1, 2, 0)), "R1 offset selects word", d, init_word(mk(1, 2, 0)));
   endtask

   task automatic t_two_ways();
      logic [31:0] d; int lat; int r0;
      access(0, mk(2, 2, 1), 0, d, lat);
      r0 = rd_count;
      access(0, mk(1, 2, 1), 0, d, lat);
      check(lat == 2 && rd_count == r0, "R5 first tag kept", lat, 2);
      access(0, mk(2, 2, 1), 0, d, lat);
      check(lat == 2 && rd_count == r0, "R5 second tag in other way", lat, 2);
      check(d == init_word(mk(2, 2, 1)), "R3 matching way's word", d, init_word(mk(2, 2, 1)));
   endtask

   task automatic t_lru();
      logic [31:0] d; int lat; int r0, w0;
      access(0, mk(1, 2, 2), 0, d, lat);      // tag 2 now least recent
      w0 = wb_count;
      access(0, mk(3, 2, 0), 0, d, lat);      // evicts tag 2
      check(wb_count == w0, "R8 clean victim no write", wb_count, w0);
      r0 = rd_count;
      access(0, mk(1, 2, 0), 0, d, lat);
      check(lat == 2 && rd_count == r0, "R6 recently used tag kept", lat, 2);
      access(0, mk(2, 2, 0), 0, d, lat);
      check(rd_count == r0 + 1, "R6 least recent tag evicted", rd_count, r0 + 1);
   endtask

   task automatic t_write_hit();
      logic [31:0] d; int lat; int r0, w0;
      access(0, mk(4, 5, 0), 0, d, lat);
      r0 = rd_count; w0 = wb_count;
      access(1, mk(4, 5, 2), 32'h0000_1234, d, lat);
      check(lat == 2 && rd_count == r0 && wb_count == w0, "R4 store hit no traffic", lat, 2);
      check(mem_words[mk(4, 5, 2)] == init_word(mk(4, 5, 2)), "R4 memory untouched",
            mem_words[mk(4, 5, 2)], init_word(mk(4, 5, 2)));
      access(0, mk(4, 5, 2), 0, d, lat);
      check(d == 32'h0000_1234, "R4 read returns stored value", d, 32'h0000_1234);
      access(0, mk(4, 5, 1), 0, d, lat);
      check(d == init_word(mk(4, 5, 1)), "R4 neighbour word unchanged", d, init_word(mk(4, 5, 1)));
   endtask

   // dirty eviction and a store merge in the same set
   task automatic t_dirty_evict();
      logic [31:0] d; int lat; int w0, r0;
      access(0, mk(6, 5, 0), 0, d, lat);      // fills second way, tag 4 least recent
      w0 = wb_count; r0 = rd_count;
      access(1, mk(7, 5, 3), 32'h0000_BEEF, d, lat);
      check(wb_count == w0 + 1, "R8 modified victim written", wb_count, w0 + 1);
      check(last_wb_addr == mk(4, 5, 0) >> 2, "R8 write-back address", last_wb_addr, mk(4, 5, 0) >> 2);
      check(wb_seq < rd_seq && rd_count == r0 + 1, "R8 write-back before refill", wb_seq, rd_seq);
      check(mem_words[mk(4, 5, 2)] == 32'h0000_1234, "R8 full block written",
            mem_words[mk(4, 5, 2)], 32'h0000_1234);
      check(mem_words[mk(4, 5, 1)] == init_word(mk(4, 5, 1)), "R8 other words intact",
            mem_words[mk(4, 5, 1)], init_word(mk(4, 5, 1)));
      access(0, mk(7, 5, 3), 0, d, lat);
      check(lat == 2 && d == 32'h0000_BEEF, "R7 store applied after fill", d, 32'h0000_BEEF);
      w0 = wb_count;
      access(0, mk(4, 5, 2), 0, d, lat);      // evicts clean tag 6
      check(wb_count == w0, "R8 clean victim silent", wb_count, w0);
      check(d == 32'h0000_1234, "R8 evicted data back from memory", d, 32'h0000_1234);
   endtask

   task automatic t_reset_clears();
      logic [31:0] d; int lat; int r0, w0;
      access(0, mk(8, 1, 0), 0, d, lat);
      access(1, mk(8, 1, 0), 32'h0000_0055, d, lat);
      do_reset();
      t_reset_state();
      r0 = rd_count; w0 = wb_count;
      access(0, mk(8, 1, 0), 0, d, lat);
      check(rd_count == r0 + 1, "R10 access misses after reset", rd_count, r0 + 1);
      check(d == init_word(mk(8, 1, 0)), "R10 store discarded", d, init_word(mk(8, 1, 0)));
      access(0, mk(9, 1, 0), 0, d, lat);
      access(0, mk(10, 1, 0), 0, d, lat);
      check(wb_count == w0, "R10 no write-back after reset", wb_count, w0);
   endtask

   initial begin
      for (int i = 0; i < (1 << ADDR_W); i++) mem_words[i] = init_word(i);
      do_reset();
      t_reset_state();
      t_miss_then_hit();
      t_two_ways();
      t_lru();
      t_write_hit();
      t_dirty_evict();
      t_reset_clears();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end
endmodule